// File: doc/BRIEF.md
# Nesting-Counter Interrupt Controller

This block collects eight interrupt request lines for a small processor and hands the processor one request at a time as a vector index. Each source has its own enable bit. On top of the per-source enables sits a single global gate, a five-bit nesting counter. Delivery happens only while that counter is zero. Software raises the counter by writing a "hold" address and lowers it by writing a "release" address; the data value of those writes is ignored. When the processor accepts a request, the counter goes up by one on its own. A handler therefore ends with a write to the release address, which lets nested masking sections and handlers balance each other.

Every request line feeds a pending latch that is set on a rising edge and cleared when that source is accepted. A source latches even while it is disabled or masked, so no edge is lost. Among the sources that are pending and enabled, the highest-numbered one wins. Changes made by software to the enables or to the counter reach the delivery logic through a fixed six-cycle pipeline. An acceptance masks further delivery from the very next cycle.

The request output is a valid/ready pair. `irq_valid` with `irq_vector` offers the winning source. The transfer takes place on a clock edge where `irq_valid` and `irq_ready` are both high. The offer is not held under back-pressure: while `irq_ready` is low, `irq_valid` may drop and `irq_vector` may change, because a higher source may arrive or the mask may close. The processor must sample the vector in the same cycle in which it asserts `irq_ready`. The register bus is a plain single-cycle port. Writes take effect on the clock edge. Read data is combinational from the address.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset the source-enable register reads 0, the nesting counter reads 0, all pending latches are clear and `irq_valid` is low.
- R2: The address map is as follows. Address 0 is the source-enable register (read/write, bit n enables source n). Address 1 is hold (write-only). Address 2 is release (write-only). Address 3 is the nesting counter (read/write through data bits 4:0, read zero-extended). Reads of addresses 1 and 2 return 0.
- R3: Any write to address 1 adds one to the counter, whatever the data, and the counter saturates at 31.
- R4: Any write to address 2 subtracts one from the counter, whatever the data, and a counter of 0 stays at 0.
- R5: A pending latch is set by a 0-to-1 transition of its request line, whether or not the source is enabled or masked. It is cleared when that source is accepted. A new rising edge in the same cycle as the acceptance keeps it set.
- R6: `irq_valid` is high only when the effective counter is zero and at least one source is both pending and effectively enabled. `irq_vector` is then the highest such source index.
- R7: A write to address 0, 1, 2 or 3 changes delivery starting exactly 6 clock edges after the write edge, counting the write edge itself. Before that, delivery follows the previous settings.
- R8: An acceptance (`irq_valid && irq_ready` at an edge) adds one to the counter, saturating at 31. It also forces `irq_valid` low from the next cycle until a zero counter has propagated through the 6-cycle pipeline again.
- R9: An acceptance and a release write at the same edge cancel, leaving the counter unchanged. An acceptance and a hold write at the same edge add two, saturating at 31. A write to address 3 at the same edge overrides the acceptance increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq_req | input | 8 | Interrupt request lines, rising edge sensitive |
| irq_valid | output | 1 | A request is offered |
| irq_ready | input | 1 | Processor accepts the offered request |
| irq_vector | output | 3 | Index of the offered source |

## Verification
A register write lands on its write edge, so a readback in the next cycle already shows the new enable or counter value. The effect of that write on `irq_valid` and `irq_vector` is due at the sixth edge. The bench samples at the falling edge after the fourth following edge and expects the old delivery, then samples again after the fifth following edge and expects the new one. A request edge shows on the outputs one edge after it is sampled, and an acceptance drops `irq_valid` one edge later. After an acceptance with the counter still zero, delivery returns five edges after the acceptance edge, and the bench checks both sides of that edge as well. All checks sample at falling edges after inputs were driven at the previous falling edge, so each count of edges is exact.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_SRC_EN  = 2'd0,
    REG_HOLD    = 2'd1,
    REG_RELEASE = 2'd2,
    REG_NEST    = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic src_en_wr;
    logic hold_wr;
    logic release_wr;
    logic nest_wr;
  } bus_cmd_t;

endpackage

// File: rtl/irq_nest_counter.sv
module irq_nest_counter #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_wr,
  input  logic             release_wr,
  input  logic             nest_wr,
  input  logic [CNT_W-1:0] nest_wdata,
  input  logic             accept,
  output logic [CNT_W-1:0] nest_q
);

  localparam int unsigned SUM_W = CNT_W + 2;
  localparam logic [SUM_W-1:0] SAT_MAX = SUM_W'((1 << CNT_W) - 1);

  logic [1:0]       inc_amt;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] adj;
  logic [CNT_W-1:0] nest_d;

  always_comb begin
    inc_amt = {1'b0, accept} + {1'b0, hold_wr};
    sum     = {2'b00, nest_q} + SUM_W'(inc_amt);
    adj     = sum;
    if (release_wr && (sum != '0)) begin
      adj = sum - SUM_W'(1);
    end
    if (nest_wr) begin
      nest_d = nest_wdata;
    end else if (adj > SAT_MAX) begin
      nest_d = SAT_MAX[CNT_W-1:0];
    end else begin
      nest_d = adj[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nest_q <= '0;
    end else begin
      nest_q <= nest_d;
    end
  end

endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_nest_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               accept,
  output logic [NUM_SRC-1:0] src_en_q,
  output logic [CNT_W-1:0]   nest_q
);

  bus_cmd_t cmd;

  always_comb begin
    cmd            = '0;
    cmd.src_en_wr  = bus_we && (bus_addr == REG_SRC_EN);
    cmd.hold_wr    = bus_we && (bus_addr == REG_HOLD);
    cmd.release_wr = bus_we && (bus_addr == REG_RELEASE);
    cmd.nest_wr    = bus_we && (bus_addr == REG_NEST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_en_q <= '0;
    end else if (cmd.src_en_wr) begin
      src_en_q <= bus_wdata[NUM_SRC-1:0];
    end
  end

  irq_nest_counter #(
    .CNT_W (CNT_W)
  ) counter_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_wr    (cmd.hold_wr),
    .release_wr (cmd.release_wr),
    .nest_wr    (cmd.nest_wr),
    .nest_wdata (bus_wdata[CNT_W-1:0]),
    .accept     (accept),
    .nest_q     (nest_q)
  );

  always_comb begin
    unique case (bus_addr)
      REG_SRC_EN: bus_rdata = DATA_W'(src_en_q);
      REG_NEST:   bus_rdata = DATA_W'(nest_q);
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_delay_line.sv
module irq_delay_line #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_in;
    if (s == 0) begin : g_head
      assign stage_in = d;
    end else begin : g_body
      assign stage_in = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= RST_VAL;
      end else if (flush) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_in;
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned VEC_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               accept,
  input  logic [VEC_W-1:0]   accept_vec,
  output logic [NUM_SRC-1:0] pend_q
);

  logic [NUM_SRC-1:0] req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
    end else begin
      req_q <= irq_req;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic rise;
    logic clr;
    assign rise = irq_req[i] && !req_q[i];
    assign clr  = accept && (accept_vec == VEC_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[i] <= 1'b0;
      end else if (rise) begin
        pend_q[i] <= 1'b1;
      end else if (clr) begin
        pend_q[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned VEC_W   = 3
) (
  input  logic [NUM_SRC-1:0] cand,
  output logic               any,
  output logic [VEC_W-1:0]   vec
);

  always_comb begin
    any = 1'b0;
    vec = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i]) begin
        any = 1'b1;
        vec = VEC_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 8,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CNT_W      = 5,
  parameter int unsigned MASK_DELAY = 6,
  localparam int unsigned VEC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] irq_req,
  output logic               irq_valid,
  input  logic               irq_ready,
  output logic [VEC_W-1:0]   irq_vector
);

  localparam int unsigned PIPE_STAGES = MASK_DELAY - 1;

  logic [NUM_SRC-1:0] src_en_q;
  logic [CNT_W-1:0]   nest_q;
  logic [NUM_SRC-1:0] src_en_eff;
  logic               nest_zero_eff;
  logic [NUM_SRC-1:0] pend_q;
  logic               cand_any;
  logic               accept;

  assign accept = irq_valid && irq_ready;

  irq_regs #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .accept    (accept),
    .src_en_q  (src_en_q),
    .nest_q    (nest_q)
  );

  irq_delay_line #(
    .W       (NUM_SRC),
    .STAGES  (PIPE_STAGES),
    .RST_VAL ('0)
  ) en_dly_i (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (1'b0),
    .d     (src_en_q),
    .q     (src_en_eff)
  );

  irq_delay_line #(
    .W       (1),
    .STAGES  (PIPE_STAGES),
    .RST_VAL (1'b1)
  ) zero_dly_i (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (accept),
    .d     (nest_q == '0),
    .q     (nest_zero_eff)
  );

  irq_pending #(
    .NUM_SRC (NUM_SRC),
    .VEC_W   (VEC_W)
  ) pend_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .accept     (accept),
    .accept_vec (irq_vector),
    .pend_q     (pend_q)
  );

  irq_prio #(
    .NUM_SRC (NUM_SRC),
    .VEC_W   (VEC_W)
  ) prio_i (
    .cand (pend_q & src_en_eff),
    .any  (cand_any),
    .vec  (irq_vector)
  );

  assign irq_valid = cand_any && nest_zero_eff;

endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned VEC_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         bus_addr,
  input logic               bus_we,
  input logic               irq_valid,
  input logic               irq_ready,
  input logic [VEC_W-1:0]   irq_vector,
  input logic [NUM_SRC-1:0] pend,
  input logic [CNT_W-1:0]   nest
);

  localparam logic [CNT_W-1:0] NEST_MAX = '1;

  logic acc;
  logic hold_w;
  logic rel_w;
  assign acc    = irq_valid && irq_ready;
  assign hold_w = bus_we && (bus_addr == 2'd1);
  assign rel_w  = bus_we && (bus_addr == 2'd2);

  assert_accept_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !irq_valid);

  assert_accept_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !bus_we && (nest != NEST_MAX)) |=> (nest == $past(nest) + 1'b1));

  assert_hold_saturates_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_w && !acc && (nest == NEST_MAX)) |=> (nest == NEST_MAX));

  assert_release_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_w && !acc && (nest == '0)) |=> (nest == '0));

  assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_w && acc) |=> $stable(nest));

  assert_offer_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> pend[irq_vector]);

endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(
  .NUM_SRC (NUM_SRC),
  .CNT_W   (CNT_W),
  .VEC_W   (VEC_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .irq_valid  (irq_valid),
  .irq_ready  (irq_ready),
  .irq_vector (irq_vector),
  .pend       (pend_q),
  .nest       (nest_q)
);

// File: tb/irq_nest_ctrl_tb_top.sv
module irq_nest_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] irq_req = '0;
  logic       irq_valid;
  logic       irq_ready = 1'b0;
  logic [2:0] irq_vector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_nest_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_req    (irq_req),
    .irq_valid  (irq_valid),
    .irq_ready  (irq_ready),
    .irq_vector (irq_vector)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  task automatic expect_irq(input string tag, input int vld, input int vec);
    chk({tag, " valid"}, int'(irq_valid), vld);
    if (vld != 0) chk({tag, " vector"}, int'(irq_vector), vec);
  endtask

  function automatic int top_bit(input int p);
    int r = 0;
    for (int i = 0; i < 8; i++) if (p[i]) r = i;
    return r;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int v;
    int prev;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 valid", int'(irq_valid), 0);
    rd(2'd0, v); chk("R1 enable", v, 0);
    rd(2'd3, v); chk("R1 nest", v, 0);
    // R2 write-only addresses read 0
    rd(2'd1, v); chk("R2 hold reads 0", v, 0);
    rd(2'd2, v); chk("R2 release reads 0", v, 0);

    // R5 edges latch while disabled
    @(negedge clk); irq_req = 8'hFF;
    tick(10);
    chk("R6 disabled sources silent", int'(irq_valid), 0);
    irq_req = 8'h00;

    // R6/R7 sweep of every enable pattern
    prev = 0;
    for (int p = 0; p < 256; p++) begin
      wr(2'd0, 8'(p));
      rd(2'd0, v); chk("R2 enable readback", v, p);
      tick(3);
      expect_irq("R7 old enables before edge 6", int'(prev != 0), top_bit(prev));
      tick(1);
      expect_irq("R6 priority after edge 6", int'(p != 0), top_bit(p));
      prev = p;
    end

    // R3/R4 sweep of every counter value
    for (int c = 0; c < 32; c++) begin
      wr(2'd3, 8'(c) | 8'hE0);
      rd(2'd3, v); chk("R2 nest readback", v, c);
      wr(2'd1, 8'(c * 7));
      rd(2'd3, v); chk("R3 hold increments", v, (c == 31) ? 31 : c + 1);
      wr(2'd3, 8'(c));
      wr(2'd2, 8'(255 - c));
      rd(2'd3, v); chk("R4 release decrements", v, (c == 0) ? 0 : c - 1);
    end
    wr(2'd3, 8'd0);
    tick(6);
    expect_irq("R6 unmasked", 1, 7);

    // R7 hold and release latency
    wr(2'd1, 8'h00);
    tick(4); chk("R7 hold before edge 6", int'(irq_valid), 1);
    tick(1); chk("R7 hold at edge 6", int'(irq_valid), 0);
    wr(2'd2, 8'h00);
    tick(4); chk("R7 release before edge 6", int'(irq_valid), 0);
    tick(1); expect_irq("R7 release at edge 6", 1, 7);

    // R8 acceptance
    @(negedge clk); irq_ready = 1'b1;
    @(negedge clk); irq_ready = 1'b0;
    chk("R8 masked after accept", int'(irq_valid), 0);
    rd(2'd3, v); chk("R8 nest after accept", v, 1);
    wr(2'd2, 8'h00);
    tick(4); chk("R8 still masked", int'(irq_valid), 0);
    tick(1); expect_irq("R5 accepted source cleared", 1, 6);

    // R9 accept with release cancels
    @(negedge clk); irq_ready = 1'b1; bus_addr = 2'd2; bus_we = 1'b1;
    @(negedge clk); irq_ready = 1'b0; bus_we = 1'b0;
    chk("R8 flush after accept", int'(irq_valid), 0);
    tick(4); chk("R8 refill not yet done", int'(irq_valid), 0);
    tick(1); expect_irq("R8 refill done", 1, 5);
    rd(2'd3, v); chk("R9 accept+release cancel", v, 0);

    // R9 accept with hold adds two
    @(negedge clk); irq_ready = 1'b1; bus_addr = 2'd1; bus_we = 1'b1;
    @(negedge clk); irq_ready = 1'b0; bus_we = 1'b0;
    rd(2'd3, v); chk("R9 accept+hold", v, 2);
    wr(2'd3, 8'd0);
    tick(5); expect_irq("R6 next source", 1, 4);

    // R5 fresh edge re-latches a cleared source
    @(negedge clk); irq_req = 8'h80;
    @(negedge clk);
    expect_irq("R5 new edge", 1, 7);

    // R9 nest write overrides acceptance
    @(negedge clk); irq_ready = 1'b1; bus_addr = 2'd3; bus_wdata = 8'd9; bus_we = 1'b1;
    @(negedge clk); irq_ready = 1'b0; bus_we = 1'b0;
    rd(2'd3, v); chk("R9 nest write wins", v, 9);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule